// File: doc/BRIEF.md
# Cascadable RAM Tile Chain

This block builds one deep single-port memory out of several identical RAM tiles stacked from the bottom to the top. Each tile has its own storage and passes the request upward over a dedicated control cascade (enable, write select, full address) and a dedicated data cascade (write data, byte strobes, and on the way back the read word, a read-response flag and two error markers). The upper address bits pick one tile, and only that tile executes the access. The top tile is the exit point: its read word, response flag and markers are the block's outputs.

Each tile carries two role settings, one for the control chain and one for the data chain, each SOLO, HEAD, MID or TAIL. A tile in the SOLO or HEAD role takes that path from the host request, and a tile in the MID or TAIL role takes it from the tile below. Host-side inputs can be registered by one switch, cascade inputs by another, and the local read word by a third. Every cascade register on the request side is matched by one on the return side, so a read has the same latency whichever tile holds the word. The two error markers are not computed: they are stored with each write and returned with the read.

Requests use a valid-only stream: `req_valid` qualifies one request per cycle and the block never applies back-pressure, so there is no ready signal. Responses are a valid-only stream as well: `rsp_valid` marks a read-result beat that cannot be stalled, and the consumer must take it in that cycle. Between beats the output holds the last read result.

Top module: `cascram_chain`

## Requirements
- R1: A role pair is legal only for control SOLO with data SOLO; control HEAD with data SOLO or HEAD; control MID with any data role; control TAIL with data SOLO or TAIL. Any other pair stops elaboration. Role codes are SOLO=0, HEAD=1, MID=2, TAIL=3.
- R2: Address bits above the tile's local index (local index width = log2 of TILE_DEPTH) select the tile. Only the tile whose index matches executes the access, so equal low addresses in different tiles hold independent words.
- R3: On a write, strobe bit b of `req_wstrb` writes data bits 8b+7 down to 8b. Bytes with a clear strobe keep their old value.
- R4: A read returns its word and raises `rsp_valid` exactly IN_REG + (NUM_TILES-1)*CAS_REG + 1 + OUT_REG cycles after the request is sampled, whichever tile holds the word.
- R5: In a cycle without a read result, `rsp_valid` is 0 and `rsp_rdata`, `rsp_sbit` and `rsp_dbit` hold the last read result.
- R6: A write never raises `rsp_valid`.
- R7: A request whose tile-select bits are NUM_TILES or above is ignored: no storage changes and no response.
- R8: Each executed write stores `req_sbit` and `req_dbit`, whatever the strobes are. A read of that word returns them on `rsp_sbit` and `rsp_dbit` alongside the data.
- R9: One request may be issued every cycle. Results leave in issue order, a read right after a write to the same word returns the new word, and two tiles never drive a read result for the same cycle.
- R10: During and right after reset, `rsp_valid`, `rsp_rdata`, `rsp_sbit` and `rsp_dbit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address; upper bits select the tile |
| req_wdata | input | DATA_W | Write word |
| req_wstrb | input | DATA_W/8 | Byte strobes for a write |
| req_sbit | input | 1 | Single-bit error marker stored with a write |
| req_dbit | input | 1 | Double-bit error marker stored with a write |
| rsp_valid | output | 1 | Read-result beat |
| rsp_rdata | output | DATA_W | Read word, held between beats |
| rsp_sbit | output | 1 | Single-bit marker of the read word, held |
| rsp_dbit | output | 1 | Double-bit marker of the read word, held |

## Verification
The assertions check the timing side on every cycle. A response beat appears exactly the fixed latency after each in-range read request and at no other time. The exit output stays unchanged in every cycle without a beat. No tile sees its own read and a cascaded read in the same cycle, and a write never produces a read flag. Only the bench scenarios show that the right word comes back: tile selection against equal low addresses, byte-strobe merging, the stored error markers, ignored out-of-range requests, read-after-write ordering in a back-to-back stream, and the role-pair table.

// File: rtl/cascram_pkg.sv
package cascram_pkg;

  typedef enum logic [1:0] {
    CAS_SOLO = 2'd0,
    CAS_HEAD = 2'd1,
    CAS_MID  = 2'd2,
    CAS_TAIL = 2'd3
  } cas_role_e;

  // Legal (control, data) role pairs; data may never reach past control.
  function automatic bit role_pair_ok(cas_role_e ctl, cas_role_e dat);
    case (ctl)
      CAS_SOLO: return dat == CAS_SOLO;
      CAS_HEAD: return (dat == CAS_SOLO) || (dat == CAS_HEAD);
      CAS_MID:  return 1'b1;
      CAS_TAIL: return (dat == CAS_SOLO) || (dat == CAS_TAIL);
      default:  return 1'b0;
    endcase
  endfunction

  // The role takes its inputs from the host request, not from below.
  function automatic bit takes_host(cas_role_e r);
    return (r == CAS_SOLO) || (r == CAS_HEAD);
  endfunction

  // The role ends a data chain and owns the exit hold register.
  function automatic bit is_exit(cas_role_e r);
    return (r == CAS_SOLO) || (r == CAS_TAIL);
  endfunction

  // Role of tile idx in a uniform chain of n tiles.
  function automatic cas_role_e chain_role(int idx, int n);
    if (n <= 1)        return CAS_SOLO;
    else if (idx == 0) return CAS_HEAD;
    else if (idx == n - 1) return CAS_TAIL;
    else               return CAS_MID;
  endfunction

endpackage

// File: rtl/cascram_pipe.sv
// Optional pipeline register: EN selects the registered or the direct path.
module cascram_pipe #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= d_i;
  end

  assign q_o = EN ? q_r : d_i;

endmodule

// File: rtl/cascram_store.sv
// Tile storage: byte-strobed write, registered read, two marker bits per word.
module cascram_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int SW   = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [SW-1:0] wstrb_i,
  input  logic [1:0]    wmark_i,
  output logic          rd_acc_o,
  output logic [DW-1:0] rd_data_o,
  output logic [1:0]    rd_mark_o
);

  logic [DW-1:0] word_mem [DEPTH];
  logic [1:0]    mark_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (acc_i && wr_i) begin
      for (int b = 0; b < SW; b++) begin
        if (wstrb_i[b]) word_mem[addr_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
      end
      mark_mem[addr_i] <= wmark_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_acc_o  <= 1'b0;
      rd_data_o <= '0;
      rd_mark_o <= '0;
    end else begin
      rd_acc_o <= acc_i && !wr_i;
      if (acc_i && !wr_i) begin
        rd_data_o <= word_mem[addr_i];
        rd_mark_o <= mark_mem[addr_i];
      end
    end
  end

  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && wr_i) |=> !rd_acc_o); // R6

endmodule

// File: rtl/cascram_tile.sv
// One tile: control and data roles chosen separately.
// Bus packing: ctrl = {en, wr, addr}; wbus = {mark[1:0], strb, data};
// rbus = {acc, mark[1:0], data}.
module cascram_tile
  import cascram_pkg::*;
#(
  parameter cas_role_e CTRL_ROLE = CAS_SOLO,
  parameter cas_role_e DATA_ROLE = CAS_SOLO,
  parameter int TILE_IDX   = 0,
  parameter int TILE_DEPTH = 16,
  parameter int ADDR_W     = 6,
  parameter int DW         = 16,
  parameter bit IN_REG     = 1'b1,
  parameter bit CAS_REG    = 1'b1,
  parameter bit OUT_REG    = 1'b1,
  localparam int TILE_AW   = $clog2(TILE_DEPTH),
  localparam int SEL_W     = ADDR_W - TILE_AW,
  localparam int SW        = DW / 8,
  localparam int CW        = 2 + ADDR_W,
  localparam int WW        = 2 + SW + DW,
  localparam int RW        = 1 + 2 + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] host_ctrl_i,
  input  logic [WW-1:0] host_wbus_i,
  input  logic [CW-1:0] cas_ctrl_i,
  input  logic [WW-1:0] cas_wbus_i,
  input  logic [RW-1:0] cas_rbus_i,
  output logic [CW-1:0] cas_ctrl_o,
  output logic [WW-1:0] cas_wbus_o,
  output logic [RW-1:0] cas_rbus_o
);

  localparam bit CTRL_HOST = takes_host(CTRL_ROLE);
  localparam bit DATA_HOST = takes_host(DATA_ROLE);
  localparam bit CTRL_PIPE = CTRL_HOST ? IN_REG : CAS_REG;
  localparam bit DATA_PIPE = DATA_HOST ? IN_REG : CAS_REG;

  // R1: reject an illegal role pair while elaborating
  if (!role_pair_ok(CTRL_ROLE, DATA_ROLE)) begin : g_bad_roles
    $fatal(1, "cascram_tile: illegal control/data role pair");
  end

  // ---------------- request side ----------------
  logic [CW-1:0] ctrl_src, ctrl_q;
  logic [WW-1:0] wbus_src, wbus_q;

  assign ctrl_src = CTRL_HOST ? host_ctrl_i : cas_ctrl_i;
  assign wbus_src = DATA_HOST ? host_wbus_i : cas_wbus_i;

  cascram_pipe #(.W(CW), .EN(CTRL_PIPE)) u_ctrl_pipe (
    .clk(clk), .rst_n(rst_n), .d_i(ctrl_src), .q_o(ctrl_q)
  );

  cascram_pipe #(.W(WW), .EN(DATA_PIPE)) u_wbus_pipe (
    .clk(clk), .rst_n(rst_n), .d_i(wbus_src), .q_o(wbus_q)
  );

  // The full request travels upward unchanged.
  assign cas_ctrl_o = ctrl_q;
  assign cas_wbus_o = wbus_q;

  logic              req_en, req_wr, hit;
  logic [ADDR_W-1:0] req_addr;
  logic [DW-1:0]     req_data;
  logic [SW-1:0]     req_strb;
  logic [1:0]        req_mark;

  assign {req_en, req_wr, req_addr}     = ctrl_q;
  assign {req_mark, req_strb, req_data} = wbus_q;
  assign hit = req_en && (req_addr[ADDR_W-1:TILE_AW] == SEL_W'(TILE_IDX));

  // ---------------- storage ----------------
  logic          st_acc;
  logic [DW-1:0] st_data;
  logic [1:0]    st_mark;

  cascram_store #(.DEPTH(TILE_DEPTH), .DW(DW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_i    (hit),
    .wr_i     (req_wr),
    .addr_i   (req_addr[TILE_AW-1:0]),
    .wdata_i  (req_data),
    .wstrb_i  (req_strb),
    .wmark_i  (req_mark),
    .rd_acc_o (st_acc),
    .rd_data_o(st_data),
    .rd_mark_o(st_mark)
  );

  // ---------------- return side ----------------
  logic [RW-1:0] loc_rbus, cas_rbus_q, below_rbus, mrg_rbus;
  logic          loc_acc, below_acc;

  cascram_pipe #(.W(RW), .EN(OUT_REG)) u_out_pipe (
    .clk(clk), .rst_n(rst_n), .d_i({st_acc, st_mark, st_data}), .q_o(loc_rbus)
  );

  // Each cascade stage on the way up is mirrored on the way back down
  // the latency ladder, so every tile's result lands on the same cycle.
  cascram_pipe #(.W(RW), .EN(CAS_REG)) u_ret_pipe (
    .clk(clk), .rst_n(rst_n), .d_i(cas_rbus_i), .q_o(cas_rbus_q)
  );

  assign below_rbus = DATA_HOST ? '0 : cas_rbus_q;
  assign loc_acc    = loc_rbus[RW-1];
  assign below_acc  = below_rbus[RW-1];
  assign mrg_rbus   = loc_acc ? loc_rbus : below_rbus;

  if (is_exit(DATA_ROLE)) begin : g_exit
    logic [RW-2:0] hold_q;
    always_ff @(posedge clk) begin
      if (!rst_n)             hold_q <= '0;
      else if (mrg_rbus[RW-1]) hold_q <= mrg_rbus[RW-2:0];
    end
    assign cas_rbus_o = mrg_rbus[RW-1] ? mrg_rbus : {1'b0, hold_q};
  end else begin : g_pass
    assign cas_rbus_o = mrg_rbus;
  end

  AST_NO_READ_COLLISION: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_acc && below_acc)); // R9

endmodule

// File: rtl/cascram_chain.sv
// Top: a uniform bottom-to-top chain of NUM_TILES tiles.
module cascram_chain
  import cascram_pkg::*;
#(
  parameter int NUM_TILES  = 3,
  parameter int TILE_DEPTH = 16,
  parameter int DATA_W     = 16,
  parameter bit IN_REG     = 1'b1,
  parameter bit CAS_REG    = 1'b1,
  parameter bit OUT_REG    = 1'b1,
  localparam int TILE_AW   = $clog2(TILE_DEPTH),
  localparam int SEL_W     = (NUM_TILES > 1) ? $clog2(NUM_TILES) : 1,
  localparam int ADDR_W    = TILE_AW + SEL_W,
  localparam int STRB_W    = DATA_W / 8,
  localparam int READ_LAT  = int'(IN_REG) + (NUM_TILES - 1) * int'(CAS_REG)
                             + 1 + int'(OUT_REG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [STRB_W-1:0] req_wstrb,
  input  logic              req_sbit,
  input  logic              req_dbit,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_sbit,
  output logic              rsp_dbit
);

  localparam int CW = 2 + ADDR_W;
  localparam int WW = 2 + STRB_W + DATA_W;
  localparam int RW = 1 + 2 + DATA_W;

  logic [CW-1:0] host_ctrl;
  logic [WW-1:0] host_wbus;
  logic [CW-1:0] ctrl_link [NUM_TILES+1];
  logic [WW-1:0] wbus_link [NUM_TILES+1];
  logic [RW-1:0] rbus_link [NUM_TILES+1];

  assign host_ctrl    = {req_valid, req_write, req_addr};
  assign host_wbus    = {req_sbit, req_dbit, req_wstrb, req_wdata};
  assign ctrl_link[0] = '0;
  assign wbus_link[0] = '0;
  assign rbus_link[0] = '0;

  for (genvar i = 0; i < NUM_TILES; i++) begin : g_tile
    cascram_tile #(
      .CTRL_ROLE (chain_role(i, NUM_TILES)),
      .DATA_ROLE (chain_role(i, NUM_TILES)),
      .TILE_IDX  (i),
      .TILE_DEPTH(TILE_DEPTH),
      .ADDR_W    (ADDR_W),
      .DW        (DATA_W),
      .IN_REG    (IN_REG),
      .CAS_REG   (CAS_REG),
      .OUT_REG   (OUT_REG)
    ) u_tile (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_ctrl_i(host_ctrl),
      .host_wbus_i(host_wbus),
      .cas_ctrl_i (ctrl_link[i]),
      .cas_wbus_i (wbus_link[i]),
      .cas_rbus_i (rbus_link[i]),
      .cas_ctrl_o (ctrl_link[i+1]),
      .cas_wbus_o (wbus_link[i+1]),
      .cas_rbus_o (rbus_link[i+1])
    );
  end

  assign {rsp_valid, rsp_sbit, rsp_dbit, rsp_rdata} = rbus_link[NUM_TILES];

  // ---- latency tracker used only by the assertions below ----
  logic                in_range;
  logic [READ_LAT-1:0] issue_pipe;

  assign in_range = {1'b0, req_addr[ADDR_W-1:TILE_AW]} < (SEL_W + 1)'(NUM_TILES);

  always_ff @(posedge clk) begin
    if (!rst_n) issue_pipe <= '0;
    else begin
      issue_pipe[0] <= req_valid && !req_write && in_range;
      for (int k = 1; k < READ_LAT; k++) issue_pipe[k] <= issue_pipe[k-1];
    end
  end

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == issue_pipe[READ_LAT-1]); // R4

  AST_EXIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ($stable(rsp_rdata) && $stable(rsp_sbit) && $stable(rsp_dbit))); // R5

endmodule

// File: tb/cascram_chain_tb.sv
module cascram_chain_tb_top;
  import cascram_pkg::*;

  localparam int NT  = 3;
  localparam int DEP = 16;
  localparam int DW  = 16;
  localparam bit IR  = 1'b1;
  localparam bit CR  = 1'b1;
  localparam bit OR_ = 1'b1;
  localparam int LAT = int'(IR) + (NT - 1) * int'(CR) + 1 + int'(OR_);
  localparam int AW  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_sbit = 1'b0, req_dbit = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_wstrb = '0;
  logic          rsp_valid, rsp_sbit, rsp_dbit;
  logic [DW-1:0] rsp_rdata;

  always #4 clk = ~clk; // 125 MHz

  cascram_chain #(
    .NUM_TILES(NT), .TILE_DEPTH(DEP), .DATA_W(DW),
    .IN_REG(IR), .CAS_REG(CR), .OUT_REG(OR_)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_wstrb(req_wstrb),
    .req_sbit(req_sbit), .req_dbit(req_dbit),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_sbit(rsp_sbit), .rsp_dbit(rsp_dbit)
  );

  typedef struct packed {
    logic          wr;
    logic [5:0]    addr;
    logic [15:0]   wdata;
    logic [1:0]    wstrb;
    logic          sb;
    logic          db;
    logic          ev;
    logic [15:0]   ed;
    logic          esb;
    logic          edb;
  } vec_t;

  // addr[5:4] = tile, addr[3:0] = word; tile 3 does not exist (R7)
  localparam vec_t TBL [13] = '{
    '{1'b1, 6'h03, 16'hA111, 2'b11, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{1'b1, 6'h13, 16'hB222, 2'b11, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{1'b1, 6'h23, 16'hC333, 2'b11, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{1'b0, 6'h03, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b1, 16'hA111, 1'b0, 1'b0},
    '{1'b0, 6'h13, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b1, 16'hB222, 1'b1, 1'b0},
    '{1'b0, 6'h23, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b1, 16'hC333, 1'b0, 1'b1},
    '{1'b1, 6'h13, 16'h55EE, 2'b01, 1'b0, 1'b0, 1'b0, 16'hC333, 1'b0, 1'b1},
    '{1'b0, 6'h13, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b1, 16'hB2EE, 1'b0, 1'b0},
    '{1'b1, 6'h23, 16'hAB99, 2'b10, 1'b1, 1'b1, 1'b0, 16'hB2EE, 1'b0, 1'b0},
    '{1'b0, 6'h23, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b1, 16'hAB33, 1'b1, 1'b1},
    '{1'b1, 6'h33, 16'hFFFF, 2'b11, 1'b1, 1'b1, 1'b0, 16'hAB33, 1'b1, 1'b1},
    '{1'b0, 6'h33, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b0, 16'hAB33, 1'b1, 1'b1},
    '{1'b0, 6'h03, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b1, 16'hA111, 1'b0, 1'b0}
  };

  // back-to-back stream for R9 (read-after-write on word 0x05)
  localparam vec_t STRM [5] = '{
    '{1'b0, 6'h03, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b1, 16'hA111, 1'b0, 1'b0},
    '{1'b1, 6'h05, 16'h9999, 2'b11, 1'b0, 1'b1, 1'b0, 16'hA111, 1'b0, 1'b0},
    '{1'b0, 6'h05, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b1, 16'h9999, 1'b0, 1'b1},
    '{1'b0, 6'h13, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b1, 16'hB2EE, 1'b0, 1'b0},
    '{1'b0, 6'h23, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b1, 16'hAB33, 1'b1, 1'b1}
  };

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    req_valid = 1'b1;
    req_write = v.wr;
    req_addr  = v.addr;
    req_wdata = v.wdata;
    req_wstrb = v.wstrb;
    req_sbit  = v.sb;
    req_dbit  = v.db;
  endtask

  task automatic idle();
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  task automatic check_out(vec_t v, string tag_v, string tag_d, string tag_f);
    chk(tag_v, {31'd0, rsp_valid}, {31'd0, v.ev});
    chk(tag_d, {16'd0, rsp_rdata}, {16'd0, v.ed});
    chk(tag_f, {30'd0, rsp_sbit, rsp_dbit}, {30'd0, v.esb, v.edb});
  endtask

  function automatic bit legal_pair(int c, int d);
    return (c == 0 && d == 0) || (c == 1 && (d == 0 || d == 1)) ||
           (c == 2) || (c == 3 && (d == 0 || d == 3));
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    chk("R10 rsp_rdata in reset", {16'd0, rsp_rdata}, 32'd0);
    chk("R10 markers in reset", {30'd0, rsp_sbit, rsp_dbit}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: one request, wait the read latency, check.
    for (int i = 0; i < 13; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      idle();
      repeat (LAT - 1) @(negedge clk);
      if (TBL[i].wr) begin
        check_out(TBL[i], (i == 10) ? "R7 out-of-range write" : "R6 write no response",
                  "R5 hold data after write", "R5 hold markers after write");
      end else begin
        check_out(TBL[i], (i == 11) ? "R7 out-of-range read" : "R4 read latency",
                  (i == 7 || i == 9) ? "R3 byte strobes" :
                  (i == 11) ? "R7 no data change" : "R2 tile select data",
                  "R8 markers returned");
        @(negedge clk);
        chk("R5 valid drops after beat", {31'd0, rsp_valid}, 32'd0);
        chk("R5 data holds after beat", {16'd0, rsp_rdata}, {16'd0, TBL[i].ed});
      end
    end

    // R9: one request per cycle, results in order
    for (int s = 0; s < 5 + LAT; s++) begin
      if (s >= LAT) check_out(STRM[s-LAT], "R9 stream valid", "R9 stream data", "R9 stream markers");
      if (s < 5) drive(STRM[s]);
      else       idle();
      @(negedge clk);
    end

    // R10: reset in mid-run clears the exit
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 valid after mid reset", {31'd0, rsp_valid}, 32'd0);
    chk("R10 data after mid reset", {16'd0, rsp_rdata}, 32'd0);
    chk("R10 markers after mid reset", {30'd0, rsp_sbit, rsp_dbit}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: legal role-pair table
    for (int c = 0; c < 4; c++) begin
      for (int d = 0; d < 4; d++) begin
        chk("R1 role pair", {31'd0, role_pair_ok(cas_role_e'(c), cas_role_e'(d))},
            {31'd0, legal_pair(c, d)});
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule